// File: doc/BRIEF.md
# Single-Correct Double-Detect Guard for External Memory

This block sits on the data path between a processor's external bus interface and a 16-bit external memory. On every protected write it computes six check bits from the outgoing data. It places them, zero-padded to a byte, on a separate check-bit lane and raises that lane's output enable for one cycle. On every protected read it takes the returned data and the check byte and forms a Hamming syndrome plus an overall-parity result. It repairs any single flipped bit and flags any pair of flipped bits as uncorrectable. The repaired word is registered on the edge that captures the read.

Protection is selected per access by a live enable input, so the system can protect some address regions and leave others bare. With the enable low, writes leave the check lane undriven, reads pass through untouched, and no status changes. A small control/status register sits at offset 15h of register window 1. It holds an interrupt mode field, a sticky uncorrectable-error flag and a saturating count of corrected single-bit errors. A registered interrupt request follows the mode.

Top module: `edac_guard`

## Requirements
- R1: A write with `wr_valid` high puts `wr_data` on `mem_wdata` on the next clock edge. When `prot_en` is also high, that edge also puts the check byte on `chk_out` and raises `chk_oe` for exactly that cycle. When `prot_en` is low, `chk_out` is 0 and `chk_oe` stays low.
- R2: Check byte layout. Number the codeword positions 1 to 21 and give data bit k the k-th position that is not a power of two (3, 5, 6, 7, 9, ...). Bit i of the check byte (i = 0..4) is the XOR of the data bits whose position has bit i set. Bit 5 is the XOR of all 16 data bits and check bits 0..4. Bits 7..6 are 0.
- R3: A protected read with a consistent data/check pair returns `mem_rdata` on `rd_data` one edge later and changes no status.
- R4: A protected read with exactly one flipped bit among the 16 data bits and check bits 0..5 returns the original data and adds one to the corrected-error count.
- R5: A protected read with exactly two flipped bits among those 22 bits sets the sticky double-error flag, returns the received data unmodified and leaves the count unchanged.
- R6: With `prot_en` low, a read returns `mem_rdata` unmodified and changes neither the count, the flag nor `irq`, whatever the check byte holds.
- R7: The corrected-error count saturates at 15.
- R8: The status register is selected when `reg_window` = 1 and `reg_addr` = 15h. `reg_rdata` shows it one edge after selection, with bit 7 = 0, bits 6..5 = interrupt mode, bit 4 = double-error flag and bits 3..0 = count. Any other window or offset reads 0.
- R9: A write to the status register (`reg_we` high while selected) loads the mode from `reg_wdata[6:5]` and clears the count and flag. An error event in the same cycle is recorded after the clear. A write to any other window or offset is ignored.
- R10: `irq` is registered and changes on the same edge as the status. Mode 00 keeps it low. Mode 01 raises it while the double-error flag is set. Modes 10 and 11 raise it while the flag is set or the count is non-zero.
- R11: Check byte bits 7..6 on `chk_in` are ignored on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_en | input | 1 | Per-access protection enable |
| wr_valid | input | 1 | Write data present this cycle |
| wr_data | input | 16 | Data from the bus interface |
| mem_wdata | output | 16 | Registered data toward memory |
| chk_out | output | 8 | Registered check byte toward memory |
| chk_oe | output | 1 | Output enable for the check-byte lane |
| rd_valid | input | 1 | Read data present this cycle |
| mem_rdata | input | 16 | Data returned by memory |
| chk_in | input | 8 | Check byte returned by memory |
| rd_data | output | 16 | Registered, corrected read data |
| reg_window | input | 4 | Register window select |
| reg_addr | input | 8 | Register offset within the window |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered register read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench flips every one of the 22 codeword bits for many data words. A decoder with a misplaced data position would repair the wrong bit or leave the fault in place. Every pair of flipped bits is also driven, including pairs that touch the overall-parity bit, which a decoder that trusts the syndrome alone would wrongly "correct". Further cases cover count saturation, a status write in the same cycle as an error, reads with protection off carrying bad check bytes, and each interrupt mode. A counter that wraps, a clear that drops the coincident event, or gating that leaks into status would each show a wrong `reg_rdata` or `irq` value.

// File: rtl/edac_pkg.sv
package edac_pkg;

  localparam int CNT_W    = 4;
  localparam int MODE_LSB = 5;
  localparam int DBL_BIT  = 4;

  typedef enum logic [1:0] {
    IRQ_OFF     = 2'b00,
    IRQ_DOUBLE  = 2'b01,
    IRQ_ANY     = 2'b10,
    IRQ_ANY_ALT = 2'b11
  } irq_mode_e;

  // Number of Hamming bits needed to cover dw data bits.
  function automatic int ham_bits(input int dw);
    int k;
    k = 1;
    while ((1 << k) < dw + k + 1) k = k + 1;
    return k;
  endfunction

  // Codeword position of data bit j: the j-th position that is not a power of two.
  function automatic int data_pos(input int j);
    int seen;
    int pos;
    seen = 0;
    pos  = 0;
    for (int p = 3; p < 256; p++) begin
      if (((p & (p - 1)) != 0) && pos == 0) begin
        if (seen == j) pos = p;
        seen = seen + 1;
      end
    end
    return pos;
  endfunction

  // Data bits covered by Hamming bit bit_i.
  function automatic logic [63:0] cover_mask(input int bit_i, input int dw);
    logic [63:0] m;
    m = '0;
    for (int j = 0; j < dw && j < 64; j++)
      if (((data_pos(j) >> bit_i) & 1) == 1) m[j] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/edac_encoder.sv
module edac_encoder
  import edac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HAM_W  = 5
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [HAM_W:0]    code_o
);

  logic [HAM_W-1:0] ham;

  for (genvar gi = 0; gi < HAM_W; gi++) begin : g_par
    localparam logic [63:0] MASK = cover_mask(gi, DATA_W);
    assign ham[gi] = ^(data_i & MASK[DATA_W-1:0]);
  end

  // Overall parity makes the full codeword XOR to zero.
  assign code_o = {^{data_i, ham}, ham};

endmodule

// File: rtl/edac_decoder.sv
module edac_decoder
  import edac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HAM_W  = 5
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [HAM_W:0]    code_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_o,
  output logic              double_o
);

  localparam int LAST_POS = DATA_W + HAM_W;

  logic [HAM_W-1:0]  syn;
  logic [DATA_W-1:0] flip;
  logic              mism;
  logic              in_range;

  for (genvar gi = 0; gi < HAM_W; gi++) begin : g_syn
    localparam logic [63:0] MASK = cover_mask(gi, DATA_W);
    assign syn[gi] = code_i[gi] ^ (^(data_i & MASK[DATA_W-1:0]));
  end

  assign mism     = ^{data_i, code_i};
  assign in_range = int'(syn) <= LAST_POS;

  // Odd flip count with a valid position: single; even count with non-zero syndrome: double.
  assign single_o = mism && in_range;
  assign double_o = (mism && !in_range) || (!mism && (syn != '0));

  for (genvar gj = 0; gj < DATA_W; gj++) begin : g_fix
    localparam int POS = data_pos(gj);
    assign flip[gj] = mism && (int'(syn) == POS);
  end

  assign data_o = data_i ^ flip;

endmodule

// File: rtl/edac_status.sv
module edac_status
  import edac_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       ev_single_i,
  input  logic       ev_double_i,
  output logic [7:0] value_o,
  output logic       irq_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]       mode_q, mode_d;
  logic             dbl_q, dbl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             unused_wdata;

  assign unused_wdata = ^{wdata_i[7], wdata_i[DBL_BIT:0]};

  always_comb begin
    mode_d = wr_i ? wdata_i[MODE_LSB+1:MODE_LSB] : mode_q;
    dbl_d  = wr_i ? 1'b0 : dbl_q;
    cnt_d  = wr_i ? '0 : cnt_q;
    if (ev_double_i) dbl_d = 1'b1;
    if (ev_single_i && (cnt_d != CNT_MAX)) cnt_d = cnt_d + CNT_W'(1);
    case (irq_mode_e'(mode_d))
      IRQ_OFF:    irq_d = 1'b0;
      IRQ_DOUBLE: irq_d = dbl_d;
      default:    irq_d = dbl_d || (cnt_d != '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 2'b00;
      dbl_q  <= 1'b0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      dbl_q  <= dbl_d;
      cnt_q  <= cnt_d;
      irq_q  <= irq_d;
    end
  end

  assign value_o = {1'b0, mode_q, dbl_q, cnt_q};
  assign irq_o   = irq_q;

  p_cnt_saturates_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !wr_i) |=> (cnt_q == CNT_MAX));

  p_dbl_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (dbl_q && !wr_i) |=> dbl_q);

  p_cnt_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_i && !ev_single_i) |=> $stable(cnt_q));

  p_dbl_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_i && !ev_double_i) |=> (dbl_q == $past(dbl_q)));

  p_write_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !ev_single_i) |=> (cnt_q == '0));

  p_irq_off_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_q == IRQ_OFF) |-> !irq_q);

endmodule

// File: rtl/edac_guard.sv
module edac_guard
  import edac_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CHK_W      = 8,
  parameter int WIN_W      = 4,
  parameter int ADDR_W     = 8,
  parameter int CSR_WINDOW = 1,
  parameter int CSR_OFFSET = 'h15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prot_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [CHK_W-1:0]  chk_out,
  output logic              chk_oe,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [CHK_W-1:0]  chk_in,
  output logic [DATA_W-1:0] rd_data,
  input  logic [WIN_W-1:0]  reg_window,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);

  localparam int HAM_W  = ham_bits(DATA_W);
  localparam int CODE_W = HAM_W + 1;
  localparam int PAD_W  = CHK_W - CODE_W;

  logic [CODE_W-1:0] enc_code;
  logic [DATA_W-1:0] dec_data;
  logic              dec_single, dec_double;
  logic              csr_hit, csr_wr;
  logic [7:0]        csr_value;
  logic              unused_chk_hi;

  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [CHK_W-1:0]  chk_q;
  logic              oe_q;
  logic [7:0]        rreg_q;

  assign unused_chk_hi = ^chk_in[CHK_W-1:CODE_W];

  edac_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) enc_i (
    .data_i (wr_data),
    .code_o (enc_code)
  );

  edac_decoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) dec_i (
    .data_i   (mem_rdata),
    .code_i   (chk_in[CODE_W-1:0]),
    .data_o   (dec_data),
    .single_o (dec_single),
    .double_o (dec_double)
  );

  assign csr_hit = (reg_window == WIN_W'(CSR_WINDOW)) && (reg_addr == ADDR_W'(CSR_OFFSET));
  assign csr_wr  = reg_we && csr_hit;

  edac_status stat_i (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (csr_wr),
    .wdata_i     (reg_wdata),
    .ev_single_i (rd_valid && prot_en && dec_single),
    .ev_double_i (rd_valid && prot_en && dec_double),
    .value_o     (csr_value),
    .irq_o       (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wdata_q <= '0;
      chk_q   <= '0;
      oe_q    <= 1'b0;
      rdata_q <= '0;
      rreg_q  <= '0;
    end else begin
      oe_q   <= wr_valid && prot_en;
      rreg_q <= csr_hit ? csr_value : 8'h00;
      if (wr_valid) begin
        wdata_q <= wr_data;
        chk_q   <= prot_en ? {{PAD_W{1'b0}}, enc_code} : '0;
      end
      if (rd_valid) rdata_q <= prot_en ? dec_data : mem_rdata;
    end
  end

  assign mem_wdata = wdata_q;
  assign chk_out   = chk_q;
  assign chk_oe    = oe_q;
  assign rd_data   = rdata_q;
  assign reg_rdata = rreg_q;

  p_oe_needs_enable_r1: assert property (@(posedge clk) disable iff (rst)
    chk_oe |-> $past(wr_valid && prot_en));

  p_bypass_read_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !prot_en) |=> (rd_data == $past(mem_rdata)));

endmodule

// File: tb/edac_guard_tb_top.sv
module edac_guard_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        prot_en, wr_valid, rd_valid, reg_we;
  logic [15:0] wr_data, mem_rdata, mem_wdata, rd_data;
  logic [7:0]  chk_out, chk_in, reg_wdata, reg_rdata, reg_addr;
  logic [3:0]  reg_window;
  logic        chk_oe, irq;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [1:0] m_mode;
  logic       m_dbl;
  logic [3:0] m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  edac_guard dut_i (
    .clk(clk), .rst(rst), .prot_en(prot_en), .wr_valid(wr_valid), .wr_data(wr_data),
    .mem_wdata(mem_wdata), .chk_out(chk_out), .chk_oe(chk_oe), .rd_valid(rd_valid),
    .mem_rdata(mem_rdata), .chk_in(chk_in), .rd_data(rd_data), .reg_window(reg_window),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_code(input logic [15:0] d);
    logic [21:0] cw;
    logic [5:0]  c;
    int k;
    cw = '0;
    k  = 0;
    for (int p = 1; p <= 21; p++)
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
    c = '0;
    for (int i = 0; i < 5; i++)
      for (int p = 1; p <= 21; p++)
        if (((p >> i) & 1) == 1) c[i] = c[i] ^ cw[p];
    c[5] = (^d) ^ (^c[4:0]);
    return {2'b00, c};
  endfunction

  function automatic logic exp_irq();
    if (m_mode == 2'b00) return 1'b0;
    if (m_mode == 2'b01) return m_dbl;
    return m_dbl || (m_cnt != 4'd0);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_write(input logic [15:0] d, input logic en, input string req);
    wr_valid = 1'b1; wr_data = d; prot_en = en;
    tick();
    wr_valid = 1'b0;
    check({req, " mem_wdata"}, 32'(mem_wdata), 32'(d));
    check({req, " chk_out"}, 32'(chk_out), en ? 32'(ref_code(d)) : 32'd0);
    check({req, " chk_oe"}, 32'(chk_oe), 32'(en));
  endtask

  // nflip: number of codeword bits flipped by the caller (0, 1 or 2)
  task automatic do_read(input logic [15:0] d, input logic [7:0] c, input logic en,
                         input int nflip, input logic [15:0] exp_d, input string req);
    rd_valid = 1'b1; mem_rdata = d; chk_in = c; prot_en = en;
    tick();
    rd_valid = 1'b0;
    if (en && nflip == 1 && m_cnt != 4'd15) m_cnt = m_cnt + 4'd1;
    if (en && nflip == 2) m_dbl = 1'b1;
    check({req, " rd_data"}, 32'(rd_data), 32'(exp_d));
    check("R10 irq", 32'(irq), 32'(exp_irq()));
  endtask

  task automatic csr_write(input logic [7:0] v);
    reg_we = 1'b1; reg_wdata = v;
    tick();
    reg_we = 1'b0;
    m_mode = v[6:5]; m_dbl = 1'b0; m_cnt = 4'd0;
    check("R10 irq after csr write", 32'(irq), 32'(exp_irq()));
  endtask

  task automatic check_csr(input string req);
    tick();
    check(req, 32'(reg_rdata), 32'({1'b0, m_mode, m_dbl, m_cnt}));
  endtask

  task automatic flip_bit(inout logic [15:0] d, inout logic [7:0] c, input int b);
    if (b < 16) d[b] = ~d[b];
    else c[b-16] = ~c[b-16];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [7:0]  c;
    rst = 1'b1; prot_en = 1'b0; wr_valid = 1'b0; rd_valid = 1'b0; reg_we = 1'b0;
    wr_data = '0; mem_rdata = '0; chk_in = '0; reg_wdata = '0;
    reg_window = 4'd1; reg_addr = 8'h15;
    m_mode = 2'b00; m_dbl = 1'b0; m_cnt = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    check("R1 reset chk_oe", 32'(chk_oe), 0);
    check("R1 reset chk_out", 32'(chk_out), 0);
    check("R3 reset rd_data", 32'(rd_data), 0);
    check("R10 reset irq", 32'(irq), 0);
    check_csr("R8 reset csr");

    // R1/R2: protected write sweep
    for (int i = 0; i < 4096; i++) do_write(16'(i * 40503), 1'b1, "R2 encode");
    do_write(16'hA5C3, 1'b0, "R1 unprotected write");
    tick();
    check("R1 chk_oe single cycle", 32'(chk_oe), 0);

    // R3: clean protected reads, R11 with junk in the pad bits
    for (int i = 0; i < 256; i++) begin
      d = 16'(i * 257 + i * 3);
      do_read(d, ref_code(d), 1'b1, 0, d, "R3 clean read");
    end
    d = 16'h1234;
    do_read(d, ref_code(d) | 8'hC0, 1'b1, 0, d, "R11 pad bits ignored");
    check_csr("R3 no status change");

    // R4/R7: every single flip
    csr_write(8'h00);
    d = 16'hBEEF; c = ref_code(d);
    flip_bit(d, c, 3);
    do_read(d, c, 1'b1, 1, 16'hBEEF, "R4 single flip");
    check_csr("R4 count one");
    for (int p = 0; p < 32; p++) begin
      for (int b = 0; b < 22; b++) begin
        d = 16'(p * 2053 + 7); c = ref_code(d);
        flip_bit(d, c, b);
        do_read(d, c, 1'b1, 1, 16'(p * 2053 + 7), "R4 corrected");
      end
    end
    check_csr("R7 saturated count");

    // R5: every flipped pair
    csr_write(8'h00);
    for (int p = 0; p < 4; p++) begin
      for (int b1 = 0; b1 < 22; b1++) begin
        for (int b2 = b1 + 1; b2 < 22; b2++) begin
          d = 16'(p * 19001 + 3); c = ref_code(d);
          flip_bit(d, c, b1);
          flip_bit(d, c, b2);
          do_read(d, c, 1'b1, 2, d, "R5 double raw data");
        end
      end
    end
    check_csr("R5 flag set count zero");

    // R6: bypass with bad check bytes
    csr_write(8'h40);
    for (int b = 0; b < 22; b++) begin
      d = 16'h0F0F; c = ref_code(d);
      flip_bit(d, c, b);
      if (b > 0) flip_bit(d, c, b - 1);
      do_read(d, c, 1'b0, 2, d, "R6 bypass data");
    end
    check_csr("R6 status untouched");

    // R8: other addresses
    reg_window = 4'd0;
    tick(); tick();
    check("R8 wrong window", 32'(reg_rdata), 0);
    reg_window = 4'd1; reg_addr = 8'h14;
    reg_we = 1'b1; reg_wdata = 8'h00;
    tick();
    reg_we = 1'b0;
    tick();
    check("R8 wrong offset", 32'(reg_rdata), 0);
    reg_addr = 8'h15;
    d = 16'h7777; c = ref_code(d); flip_bit(d, c, 20);
    do_read(d, c, 1'b1, 1, 16'h7777, "R4 flip parity bit");
    check_csr("R9 stray write ignored");

    // R9: write with a coincident single error
    d = 16'h2222; c = ref_code(d); flip_bit(d, c, 9);
    rd_valid = 1'b1; mem_rdata = d; chk_in = c; prot_en = 1'b1;
    reg_we = 1'b1; reg_wdata = 8'h20;
    tick();
    rd_valid = 1'b0; reg_we = 1'b0;
    m_mode = 2'b01; m_dbl = 1'b0; m_cnt = 4'd1;
    check("R9 coincident rd_data", 32'(rd_data), 32'h2222);
    check_csr("R9 event after clear");

    // R10: modes
    check("R10 mode01 single no irq", 32'(irq), 0);
    d = 16'h5555; c = ref_code(d); flip_bit(d, c, 0); flip_bit(d, c, 5);
    do_read(d, c, 1'b1, 2, d, "R10 mode01 double");
    check("R10 mode01 double irq", 32'(irq), 1);
    csr_write(8'h40);
    d = 16'h6666; c = ref_code(d); flip_bit(d, c, 1);
    do_read(d, c, 1'b1, 1, 16'h6666, "R10 mode10 single");
    check("R10 mode10 single irq", 32'(irq), 1);
    csr_write(8'h60);
    check("R10 mode11 cleared irq", 32'(irq), 0);
    d = 16'h6666; c = ref_code(d); flip_bit(d, c, 18);
    do_read(d, c, 1'b1, 1, 16'h6666, "R10 mode11 single");
    check("R10 mode11 single irq", 32'(irq), 1);
    csr_write(8'h00);
    d = 16'h9999; c = ref_code(d); flip_bit(d, c, 2); flip_bit(d, c, 11);
    do_read(d, c, 1'b1, 2, d, "R10 mode00 double");
    check("R10 mode00 irq low", 32'(irq), 0);
    check_csr("R8 final csr");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule